// File: doc/BRIEF.md
# Cascaded LED Driver Chain Sequencer

This block sits on the host side of a chain of 8-bit serial-in, latched-output LED driver devices. It takes one frame of `N_DEV*8` bits through a valid/ready handshake. It then runs the whole five-wire transfer on its own. First it raises the power-enable line. Next it clocks the frame out most-significant bit first on a serial data line and a serial clock. It pulses the latch line and, after a short gap, drives the active-low strobe for a programmable number of cycles. When the strobe ends it raises `done` for one cycle and drops back to the idle state.

Every interval is a count of system-clock cycles set by a parameter. When the block is elaborated, it checks each count against the interface minimums for the configured system-clock period and refuses any count that is too short. The interface minimums are: power-up lead 500 ns, data setup 300 ns, data hold 400 ns, serial clock period 2 µs, latch width 800 ns, latch-to-strobe gap 300 ns and strobe width 3 µs. The strobe width for a frame comes from an input sampled when that frame is accepted. A value on that input below the configured floor is raised to the floor.

Top module: `led_chain_seq`

## Requirements
- R1: While reset is asserted and after it is released, the outputs rest at idle: `frame_ready`=1, `drv_psw`=0, `drv_sclk`=0, `drv_sdata`=0, `drv_latch`=0, `drv_stb_n`=1, `done`=0.
- R2: `frame_ready` is high only in the idle state, and a frame is taken on a clock edge where `frame_valid` and `frame_ready` are both high. A `frame_valid` pulse while a frame is in progress is ignored and leaves the waveform unchanged.
- R3: On the cycle after acceptance, `drv_psw` rises and stays high until the cycle after `done`. The first `drv_sclk` rise comes `PWR_CYC + SETUP_CYC` cycles after `drv_psw` rises.
- R4: Frame bits leave on `drv_sdata` starting with bit `N_DEV*8-1` and ending with bit 0. Each bit is presented for `SETUP_CYC` cycles with `drv_sclk` low and is then held for `HOLD_CYC` cycles with `drv_sclk` high.
- R5: Each frame produces exactly `N_DEV*8` rising edges on `drv_sclk`, and `drv_sclk` is low at all other times.
- R6: After the last `drv_sclk` high phase, `drv_sclk` stays low and the last bit stays on `drv_sdata` for `LGAP_CYC` cycles. `drv_latch` is then high for `LATCH_CYC` cycles.
- R7: After `drv_latch` falls, `drv_stb_n` stays high for `SGAP_CYC` cycles. It is then low for the number of cycles in `strobe_len` sampled at acceptance.
- R8: `done` is high for exactly one cycle, right after the strobe ends. On the next cycle the block is idle, with `drv_psw` low and `frame_ready` high.
- R9: A `strobe_len` below `STB_MIN_CYC`, including zero, gives a strobe low time of exactly `STB_MIN_CYC` cycles.
- R10: Changing `strobe_len` after a frame has been accepted has no effect on that frame's strobe width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_valid | input | 1 | A frame is offered |
| frame_ready | output | 1 | The block is idle and will take a frame |
| frame_data | input | N_DEV*8 | Frame bits; the top bit is sent first |
| strobe_len | input | LEN_W | Requested strobe low time in cycles |
| drv_psw | output | 1 | Power enable to the driver chain |
| drv_sdata | output | 1 | Serial data to the first device |
| drv_sclk | output | 1 | Serial shift clock |
| drv_latch | output | 1 | Latch pulse, active high |
| drv_stb_n | output | 1 | Output strobe, active low |
| done | output | 1 | One-cycle pulse at the end of a frame |

## Verification
The assertions assume that reset is asserted at time zero and that all inputs change synchronously to `clk`. They place no limits on `frame_valid` or `strobe_len`. The ignore rule is therefore checked only against the outputs: whatever the host drives while the block is busy must not disturb them. The bench changes its inputs only on the falling clock edge. It offers frames only when it expects the block to be idle, apart from a deliberate one-cycle offer in mid-frame and a change to `strobe_len` in mid-frame. Its own model decides in which cycle each frame is taken.

// File: rtl/led_chain_pkg.sv
package led_chain_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PWR, ST_BIT_LO, ST_BIT_HI, ST_LGAP,
    ST_LATCH, ST_SGAP, ST_STROBE, ST_DONE
  } seq_state_t;

  // Minimum cycle count covering a time in ns, rounded up.
  function automatic int ns_to_cyc(input int ns, input int period_ns);
    return (ns + period_ns - 1) / period_ns;
  endfunction

  // Strobe length actually used: the request, raised to the floor.
  function automatic logic [15:0] eff_strobe(input logic [15:0] req,
                                             input logic [15:0] floor_cyc);
    return (req < floor_cyc) ? floor_cyc : req;
  endfunction

endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  AST_TIMER_HOLDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !load) |=> expired); // R7
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] din,
  input  logic             shift,
  output logic             msb,
  output logic             last_bit
);
  localparam int BC_W = $clog2(WIDTH + 1);

  logic [WIDTH-1:0] sreg_q;
  logic [BC_W-1:0]  left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
      left_q <= '0;
    end else if (load) begin
      sreg_q <= din;
      left_q <= BC_W'(WIDTH);
    end else if (shift) begin
      sreg_q <= {sreg_q[WIDTH-2:0], 1'b0};
      left_q <= left_q - 1'b1;
    end
  end

  assign msb      = sreg_q[WIDTH-1];
  assign last_bit = (left_q == BC_W'(1));

  AST_NO_SHIFT_PAST_END: assert property (@(posedge clk) disable iff (!rst_n)
    shift |-> (left_q > BC_W'(1))); // R5
endmodule

// File: rtl/led_chain_seq.sv
module led_chain_seq
  import led_chain_pkg::*;
#(
  parameter int N_DEV       = 2,
  parameter int CLK_NS      = 10,
  parameter int LEN_W       = 16,
  parameter int PWR_CYC     = 50,
  parameter int SETUP_CYC   = 100,
  parameter int HOLD_CYC    = 100,
  parameter int LGAP_CYC    = 20,
  parameter int LATCH_CYC   = 80,
  parameter int SGAP_CYC    = 30,
  parameter int STB_MIN_CYC = 300
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_valid,
  output logic               frame_ready,
  input  logic [N_DEV*8-1:0] frame_data,
  input  logic [LEN_W-1:0]   strobe_len,
  output logic               drv_psw,
  output logic               drv_sdata,
  output logic               drv_sclk,
  output logic               drv_latch,
  output logic               drv_stb_n,
  output logic               done
);
  localparam int FW    = N_DEV * 8;
  localparam int CNT_W = 16;

  // Elaboration-time interval checks against interface minimums.
  if (PWR_CYC < ns_to_cyc(500, CLK_NS)) begin : g_bad_pwr
    $error("power-up lead too short");
  end
  if (SETUP_CYC < ns_to_cyc(300, CLK_NS)) begin : g_bad_setup
    $error("data setup too short");
  end
  if (HOLD_CYC < ns_to_cyc(400, CLK_NS)) begin : g_bad_hold
    $error("data hold too short");
  end
  if (SETUP_CYC + HOLD_CYC < ns_to_cyc(2000, CLK_NS)) begin : g_bad_rate
    $error("serial clock faster than 500 kHz");
  end
  if (LGAP_CYC < 1) begin : g_bad_lgap
    $error("latch gap must be at least one cycle");
  end
  if (LATCH_CYC < ns_to_cyc(800, CLK_NS)) begin : g_bad_latch
    $error("latch pulse too short");
  end
  if (SGAP_CYC < ns_to_cyc(300, CLK_NS)) begin : g_bad_sgap
    $error("latch-to-strobe gap too short");
  end
  if (STB_MIN_CYC < ns_to_cyc(3000, CLK_NS)) begin : g_bad_stb
    $error("strobe floor too short");
  end
  if (LEN_W > CNT_W || STB_MIN_CYC >= (1 << CNT_W) || SETUP_CYC >= (1 << CNT_W)
      || HOLD_CYC >= (1 << CNT_W) || PWR_CYC >= (1 << CNT_W)) begin : g_bad_width
    $error("interval does not fit the timer");
  end

  seq_state_t       state_q, state_d;
  logic             tmr_load, tmr_zero;
  logic [CNT_W-1:0] tmr_val;
  logic             sh_load, sh_shift, sh_msb, sh_last;
  logic [CNT_W-1:0] stb_q;

  // Named internal events
  logic accept, bit_rise, bit_fall, strobe_end;
  assign accept     = frame_valid && frame_ready;
  assign bit_rise   = (state_q == ST_BIT_LO) && tmr_zero;
  assign bit_fall   = (state_q == ST_BIT_HI) && tmr_zero;
  assign strobe_end = (state_q == ST_STROBE) && tmr_zero;

  seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .expired(tmr_zero)
  );

  frame_shifter #(.WIDTH(FW)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(sh_load), .din(frame_data),
    .shift(sh_shift), .msb(sh_msb), .last_bit(sh_last)
  );

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    sh_load  = 1'b0;
    sh_shift = 1'b0;
    unique case (state_q)
      ST_IDLE: if (accept) begin
        state_d = ST_PWR; tmr_load = 1'b1; tmr_val = CNT_W'(PWR_CYC - 1);
        sh_load = 1'b1;
      end
      ST_PWR: if (tmr_zero) begin
        state_d = ST_BIT_LO; tmr_load = 1'b1; tmr_val = CNT_W'(SETUP_CYC - 1);
      end
      ST_BIT_LO: if (bit_rise) begin
        state_d = ST_BIT_HI; tmr_load = 1'b1; tmr_val = CNT_W'(HOLD_CYC - 1);
      end
      ST_BIT_HI: if (bit_fall) begin
        tmr_load = 1'b1;
        if (sh_last) begin
          state_d = ST_LGAP; tmr_val = CNT_W'(LGAP_CYC - 1);
        end else begin
          state_d = ST_BIT_LO; tmr_val = CNT_W'(SETUP_CYC - 1);
          sh_shift = 1'b1;
        end
      end
      ST_LGAP: if (tmr_zero) begin
        state_d = ST_LATCH; tmr_load = 1'b1; tmr_val = CNT_W'(LATCH_CYC - 1);
      end
      ST_LATCH: if (tmr_zero) begin
        state_d = ST_SGAP; tmr_load = 1'b1; tmr_val = CNT_W'(SGAP_CYC - 1);
      end
      ST_SGAP: if (tmr_zero) begin
        state_d = ST_STROBE; tmr_load = 1'b1; tmr_val = stb_q - 1'b1;
      end
      ST_STROBE: if (strobe_end) state_d = ST_DONE;
      ST_DONE:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      stb_q   <= CNT_W'(STB_MIN_CYC);
    end else begin
      state_q <= state_d;
      if (accept) stb_q <= eff_strobe(CNT_W'(strobe_len), CNT_W'(STB_MIN_CYC));
    end
  end

  assign frame_ready = (state_q == ST_IDLE);
  assign drv_psw     = (state_q != ST_IDLE);
  assign drv_sclk    = (state_q == ST_BIT_HI);
  assign drv_sdata   = sh_msb && ((state_q == ST_BIT_LO) || (state_q == ST_BIT_HI)
                                  || (state_q == ST_LGAP));
  assign drv_latch   = (state_q == ST_LATCH);
  assign drv_stb_n   = (state_q != ST_STROBE);
  assign done        = (state_q == ST_DONE);

  AST_SCLK_NEEDS_PSW: assert property (@(posedge clk) disable iff (!rst_n)
    drv_sclk |-> drv_psw); // R3
  AST_DATA_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_sclk && $past(drv_sclk)) |-> $stable(drv_sdata)); // R4
  AST_LATCH_SCLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    drv_latch |-> !drv_sclk); // R6
  AST_STROBE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_stb_n |-> (!drv_latch && !drv_sclk)); // R7
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ready |-> (!drv_psw && drv_stb_n && !drv_latch)); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && frame_ready)); // R8
  AST_STB_AFTER_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drv_latch) |-> drv_stb_n); // R7
endmodule

// File: tb/led_chain_seq_bench.sv
module led_chain_seq_bench;
  localparam int NDEV = 2;
  localparam int FW   = NDEV * 8;
  localparam int P_PWR = 50, P_SET = 100, P_HLD = 100, P_LG = 20;
  localparam int P_LAT = 80, P_SG = 30, P_SMIN = 300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_valid = 1'b0;
  logic [FW-1:0] frame_data = '0;
  logic [15:0] strobe_len = '0;
  logic frame_ready, drv_psw, drv_sdata, drv_sclk, drv_latch, drv_stb_n, done;

  always #5 clk = ~clk;

  led_chain_seq #(
    .N_DEV(NDEV), .CLK_NS(10), .LEN_W(16), .PWR_CYC(P_PWR), .SETUP_CYC(P_SET),
    .HOLD_CYC(P_HLD), .LGAP_CYC(P_LG), .LATCH_CYC(P_LAT), .SGAP_CYC(P_SG),
    .STB_MIN_CYC(P_SMIN)
  ) u_led_chain_seq (
    .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .frame_ready(frame_ready),
    .frame_data(frame_data), .strobe_len(strobe_len), .drv_psw(drv_psw),
    .drv_sdata(drv_sdata), .drv_sclk(drv_sclk), .drv_latch(drv_latch),
    .drv_stb_n(drv_stb_n), .done(done)
  );

  // Expected vector: {ready, psw, sclk, sdata, latch, stb_n, done}
  localparam logic [6:0] IDLE_V = 7'b1000010;
  logic [6:0] exp_q[$];
  logic [6:0] cur = IDLE_V;
  int n_cmp = 0, n_bad = 0, cycles = 0;
  int rises = 0, low_run = 0, exp_stb = 0;
  string stb_tag = "R7";
  logic prev_clk = 1'b0, prev_stb = 1'b1;
  bit finished = 1'b0;

  function automatic logic [6:0] vec(input bit c, input bit d, input bit l,
                                     input bit s_n, input bit dn);
    return {1'b0, 1'b1, c, d, l, s_n, dn};
  endfunction

  task automatic build(input logic [FW-1:0] fr, input int len);
    int w;
    w = (len < P_SMIN) ? P_SMIN : len;
    exp_stb = w;
    for (int i = 0; i < P_PWR; i++) exp_q.push_back(vec(0, 0, 0, 1, 0));
    for (int b = FW - 1; b >= 0; b--) begin
      for (int i = 0; i < P_SET; i++) exp_q.push_back(vec(0, fr[b], 0, 1, 0));
      for (int i = 0; i < P_HLD; i++) exp_q.push_back(vec(1, fr[b], 0, 1, 0));
    end
    for (int i = 0; i < P_LG; i++)  exp_q.push_back(vec(0, fr[0], 0, 1, 0));
    for (int i = 0; i < P_LAT; i++) exp_q.push_back(vec(0, 0, 1, 1, 0));
    for (int i = 0; i < P_SG; i++)  exp_q.push_back(vec(0, 0, 0, 1, 0));
    for (int i = 0; i < w; i++)     exp_q.push_back(vec(0, 0, 0, 0, 0));
    exp_q.push_back(vec(0, 0, 0, 1, 1));
  endtask

  task automatic field(input string tag, input string nm, input logic a, input logic e);
    n_cmp++;
    if (a !== e) begin
      n_bad++;
      $display("FAIL %s %s at cycle %0d: got %b expected %b", tag, nm, cycles, a, e);
    end
  endtask

  task automatic compare(input bit in_reset);
    field(in_reset ? "R1" : "R2", "frame_ready", frame_ready, cur[6]);
    field(in_reset ? "R1" : "R3", "drv_psw",     drv_psw,     cur[5]);
    field(in_reset ? "R1" : "R5", "drv_sclk",    drv_sclk,    cur[4]);
    field(in_reset ? "R1" : "R4", "drv_sdata",   drv_sdata,   cur[3]);
    field(in_reset ? "R1" : "R6", "drv_latch",   drv_latch,   cur[2]);
    field(in_reset ? "R1" : stb_tag, "drv_stb_n", drv_stb_n,  cur[1]);
    field(in_reset ? "R1" : "R8", "done",        done,        cur[0]);
  endtask

  // Compare the present cycle, advance the model with the inputs now driven,
  // then wait for the next falling edge.
  task automatic tick();
    compare(1'b0);
    if (drv_sclk && !prev_clk) rises++;
    if (!drv_stb_n) low_run++;
    if (drv_stb_n && !prev_stb) begin
      n_cmp++;
      if (low_run != exp_stb) begin
        n_bad++;
        $display("FAIL %s strobe width: got %0d expected %0d", stb_tag, low_run, exp_stb);
      end
      low_run = 0;
    end
    prev_clk = drv_sclk;
    prev_stb = drv_stb_n;
    if (exp_q.size() == 0 && cur == IDLE_V && frame_valid) build(frame_data, int'(strobe_len));
    cur = (exp_q.size() > 0) ? exp_q.pop_front() : IDLE_V;
    cycles++;
    @(negedge clk);
  endtask

  task automatic run_frame(input logic [FW-1:0] fr, input int len, input string tag,
                           input bit poke_busy);
    int k;
    stb_tag = tag;
    rises = 0;
    frame_valid = 1'b1; frame_data = fr; strobe_len = 16'(len);
    tick();
    frame_valid = 1'b0; frame_data = ~fr;
    k = 0;
    while (cur != IDLE_V) begin
      if (poke_busy && k == 700) begin
        frame_valid = 1'b1; strobe_len = 16'd2000; // R2 R10: offered while busy
      end else begin
        frame_valid = 1'b0;
      end
      tick();
      k++;
    end
    n_cmp++;
    if (rises != FW) begin
      n_bad++;
      $display("FAIL R5 sclk rises: got %0d expected %0d", rises, FW);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compare(1'b1);                      // R1 during reset
    rst_n = 1'b1;
    @(negedge clk);
    compare(1'b1);                      // R1 after release
    tick();
    run_frame(16'hA53C, 400, "R7", 1'b0);
    run_frame(16'h0001, 0, "R9", 1'b0);  // back-to-back, clamped strobe
    repeat (5) tick();
    run_frame(16'hFFFF, 301, "R10", 1'b1);
    run_frame(16'h8000, 300, "R9", 1'b0);
    run_frame(16'h7FFE, 5, "R9", 1'b0);
    repeat (10) tick();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1_800_000;
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired at cycle %0d", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule